// File: doc/BRIEF.md
# Selectable Multi-Channel Input Qualifier

This block cleans up the outputs of field-input comparators before they reach a capture register. Each of its channels is filtered on its own. A channel's output takes a new level, rising or falling, only after the raw input has held that level for a whole qualification window. A two-bit select code, shared by all channels, chooses the window. The code can also bypass the filter so that the outputs follow the inputs directly.

The windows are counted in system-clock cycles. The parameter `CYC_PER_MS` gives the number of cycles in one millisecond. From it the block derives a long window of three milliseconds and a short window of one millisecond. The select code can change at any time. A change takes effect on the next clock edge and discards no count already made.

Top module: `field_qual_bank`

## Requirements
- R1: While `rst_ni` is low, every bit of `filt_o` is 0 in every select mode. After reset is released, every channel starts from an accepted level of 0 with no qualification count in progress.
- R2: Select decoding uses `sel_i[1]` as the upper line and `sel_i[0]` as the lower line. Code 2'b11 selects the long window of 3*CYC_PER_MS cycles. Code 2'b10 selects the short window of CYC_PER_MS cycles. Code 2'b01 selects bypass. The reserved code 2'b00 behaves exactly like 2'b11.
- R3: In a filtering mode with window N, a raw input that rises above the accepted level is accepted on the N-th consecutive rising clock edge that samples the new level. The output changes right after that edge and does not change after edge N-1.
- R4: A falling change is qualified by the same rule as in R3, with the same window.
- R5: If the raw input returns to the accepted level on any edge before acceptance, the count restarts from zero and the output does not change. A later change then needs a full window again.
- R6: Each channel counts on its own. Changes that start on different edges in different channels are accepted on each channel's own N-th edge.
- R7: In bypass, each output equals its raw input combinationally in the same cycle. This holds even when the input toggles on every clock cycle.
- R8: While in bypass, the accepted level tracks the input on every edge. When the mode leaves bypass, the output holds the last sampled input, with no extra qualification.
- R9: If the select code shortens the window while a count is in progress, the change is accepted on the first edge at which the number of consecutive differing samples, counting that edge, is at least the new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raw_i | input | NUM_CH | Raw comparator levels, one per channel |
| sel_i | input | 2 | Qualification time select code |
| filt_o | output | NUM_CH | Qualified levels, one per channel |

## Verification
A count that is wrong or fails to restart shows up at the output as an acceptance one or more edges too early or too late. The bench therefore samples the edge just before and the edge of each expected transition. If bypass state is not tracked, the fault stays hidden until the mode leaves bypass, where it appears at once as a jump in the output. A fault in select decoding shows a transition at the wrong window length: after the short window instead of the long one, or the other way round. A channel that leaks into its neighbour shows a transition at another channel's edge.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam logic [1:0] SEL_LONG  = 2'b11;
  localparam logic [1:0] SEL_SHORT = 2'b10;
  localparam logic [1:0] SEL_PASS  = 2'b01;
  localparam logic [1:0] SEL_RSVD  = 2'b00;

  typedef enum logic [1:0] {
    QM_LONG,
    QM_SHORT,
    QM_PASS
  } qual_mode_e;
endpackage

// File: rtl/fq_mode_dec.sv
module fq_mode_dec
  import fq_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int LIM_LONG  = 3000,
  parameter int LIM_SHORT = 1000
) (
  input  logic [1:0]       sel_i,
  output logic             byp_o,
  output logic [CNT_W-1:0] lim_o
);
  qual_mode_e mode;

  always_comb begin
    unique case (sel_i)
      SEL_SHORT: mode = QM_SHORT;
      SEL_PASS:  mode = QM_PASS;
      default:   mode = QM_LONG;  // reserved code folds onto long window
    endcase
  end

  always_comb begin
    byp_o = (mode == QM_PASS);
    lim_o = (mode == QM_SHORT) ? CNT_W'(LIM_SHORT) : CNT_W'(LIM_LONG);
  end

  always_comb begin
    if (sel_i == SEL_RSVD) a_r2_rsvd_is_long : assert (!byp_o && lim_o == CNT_W'(LIM_LONG));
  end
endmodule

// File: rtl/fq_chan.sv
module fq_chan #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_i,
  input  logic             byp_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             out_o
);
  logic             acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             diff;
  logic             done;

  assign diff = (in_i != acc_q);
  assign done = (cnt_q >= lim_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else if (byp_i) begin
      acc_q <= in_i;
      cnt_q <= '0;
    end else if (!diff) begin
      cnt_q <= '0;
    end else if (done) begin
      acc_q <= in_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign out_o = (byp_i && rst_ni) ? in_i : acc_q;

  a_r3_no_early : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_i && diff && !done) |=> $stable(acc_q));
  a_r9_accept : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_i && diff && done) |=> (acc_q != $past(acc_q)));
  a_r5_restart : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_i && !diff) |=> (cnt_q == '0 && $stable(acc_q)));
  a_r8_track : assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_i |=> (acc_q == $past(in_i)));
endmodule

// File: rtl/field_qual_bank.sv
module field_qual_bank #(
  parameter int NUM_CH     = 8,
  parameter int CYC_PER_MS = 1000,
  parameter int LONG_MS    = 3,
  parameter int SHORT_MS   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] raw_i,
  input  logic [1:0]        sel_i,
  output logic [NUM_CH-1:0] filt_o
);
  localparam int LIM_LONG  = LONG_MS * CYC_PER_MS;
  localparam int LIM_SHORT = SHORT_MS * CYC_PER_MS;
  localparam int CNT_W     = $clog2(LIM_LONG + 1);

  logic             byp;
  logic [CNT_W-1:0] lim;

  fq_mode_dec #(
    .CNT_W    (CNT_W),
    .LIM_LONG (LIM_LONG),
    .LIM_SHORT(LIM_SHORT)
  ) u_dec (
    .sel_i(sel_i),
    .byp_o(byp),
    .lim_o(lim)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fq_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (raw_i[g]),
      .byp_i (byp),
      .lim_i (lim),
      .out_o (filt_o[g])
    );
  end

  always_comb begin
    if (!rst_ni) a_r1_reset_low : assert (filt_o == '0);
  end

  a_r7_pass_follow : assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp |-> (filt_o == raw_i));
endmodule

// File: tb/tb_field_qual_bank.sv
module tb_field_qual_bank;
  localparam int CPM = 4;
  localparam int NL  = 3 * CPM;
  localparam int NS  = CPM;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] raw = '0;
  logic [1:0] sel = 2'b01;
  logic [7:0] filt;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         when;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  field_qual_bank #(.NUM_CH(8), .CYC_PER_MS(CPM)) dut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .raw_i (raw),
    .sel_i (sel),
    .filt_o(filt)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: filt_o=%h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // drive at negedge; expectation is for the output seen after the next posedge
  task automatic step(input logic [7:0] in, input logic [1:0] s, input logic [7:0] exp,
                      input string tag, input bit chk = 1'b1);
    item_t it;
    @(negedge clk);
    raw = in;
    sel = s;
    if (chk) begin
      it.when = cyc + 1;
      it.exp  = exp;
      it.tag  = tag;
      q.push_back(it);
    end
  endtask

  // monitor: pops items as their cycle comes due
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (q.size() > 0 && q[0].when <= cyc) begin
        item_t it;
        it = q.pop_front();
        check(filt, it.exp, it.tag);
      end
    end
  end

  initial begin
    // R1: outputs held low in reset, even in bypass with inputs high
    raw = 8'hFF;
    sel = 2'b01;
    repeat (3) @(negedge clk);
    #1 check(filt, 8'h00, "R1 reset in bypass");
    sel = 2'b11;
    @(negedge clk);
    #1 check(filt, 8'h00, "R1 reset in long mode");
    raw = 8'h00;
    rst_ni = 1'b1;
    step(8'h00, 2'b11, 8'h00, "R1 after release");

    // R3 + R2 long window: ch0 rises, accepted on edge NL
    for (int k = 1; k <= NL; k++)
      step(8'h01, 2'b11, (k == NL) ? 8'h01 : 8'h00, "R3/R2 long rise");

    // R4 + R2 short window: ch0 falls
    for (int k = 1; k <= NS; k++)
      step(8'h00, 2'b10, (k == NS) ? 8'h00 : 8'h01, "R4/R2 short fall");

    // R5: glitch back to accepted level restarts the count
    for (int k = 1; k < NS; k++) step(8'h02, 2'b10, 8'h00, "R5 pre-glitch");
    step(8'h00, 2'b10, 8'h00, "R5 glitch");
    for (int k = 1; k < NS; k++) step(8'h02, 2'b10, 8'h00, "R5 restarted count");
    step(8'h02, 2'b10, 8'h02, "R5 full window accepted");

    // R6: ch4 rises two edges before ch1 falls
    step(8'h12, 2'b10, 8'h02, "R6 e1");
    step(8'h12, 2'b10, 8'h02, "R6 e2");
    step(8'h10, 2'b10, 8'h02, "R6 e3");
    step(8'h10, 2'b10, 8'h12, "R6 ch4 accepted");
    step(8'h10, 2'b10, 8'h12, "R6 ch1 pending");
    step(8'h10, 2'b10, 8'h10, "R6 ch1 accepted");

    // R2: reserved code uses the long window
    for (int k = 1; k <= NL; k++)
      step(8'h90, 2'b00, (k == NL) ? 8'h90 : 8'h10, "R2 reserved as long");

    // R7: bypass follows every-cycle toggling, same cycle
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v;
      v = k[0] ? 8'h55 : 8'hAA;
      step(v, 2'b01, v, "R7 bypass after edge");
      #1 check(filt, v, "R7 bypass same cycle");
    end
    step(8'h5A, 2'b01, 8'h5A, "R7 bypass last");

    // R8: leaving bypass keeps last sampled input
    step(8'h5A, 2'b11, 8'h5A, "R8 hold after bypass");
    #1 check(filt, 8'h5A, "R8 hold immediately");
    step(8'h5A, 2'b11, 8'h5A, "R8 hold");

    // R9: long count in progress, then window shortened
    for (int k = 1; k <= 6; k++) step(8'h00, 2'b11, 8'h5A, "R9 long counting");
    step(8'h00, 2'b10, 8'h00, "R9 accepted on shorten");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule